// File: doc/BRIEF.md
# Double-Buffered Conversion Result Store

This block holds the conversion results of a small group of sample slots. Each slot can work as a plain result register or as a two-deep buffer. A completion strobe from the converter writes a 12-bit result into the named slot. A read strobe on the bus side returns one word for the named slot, one cycle later. The word carries the oldest unread result together with three flags: valid, second-data status and overrun. The read then consumes that result.

The double-buffer enable for each slot comes in on its own pin. It is wired from bit 23 of that slot's control word, which is held outside this block. It should change only while the slot is empty, for example right after reset.

With buffering on, the first result sets valid and leaves the status flag clear. A second unread result sets both flags. Software should therefore fetch the data once both flags read as 1.

Top module: `conv_result_bank`

## Requirements
- R1: After synchronous reset every slot is empty, the overrun flags are clear, `rd_ack` is 0 and `rd_word` is all zeros.
- R2: `rd_ack` and `rd_word` respond in the cycle after the cycle in which `rd_stb` is sampled high. `rd_word` holds its value until the next read.
- R3: Read word layout: bits 11:0 hold the result, bit 16 is overrun, bit 17 is valid and bit 18 is second-data status. All other bits are 0. The result field reads 0 whenever valid is 0, and status is never 1 while valid is 0.
- R4: Each slot's mode is chosen by its own bit in `slot_dbuf_en`: 1 gives a two-deep buffer and 0 gives a single register.
- R5: In buffered mode, after the first result in an empty slot, a read returns that result with valid 1 and status 0.
- R6: In buffered mode, with two unread results, a read returns the older one with valid 1 and status 1.
- R7: A read consumes the oldest entry. A later read reports the flags of what remains, so an empty slot returns valid 0.
- R8: A result that arrives while a buffered slot holds two unread entries discards the oldest entry, keeps the new one and sets the slot's sticky overrun flag.
- R9: In single mode each result replaces the stored one and sets valid. Status always reads 0. Replacing an unread result sets overrun.
- R10: A read of a slot reports its overrun flag and then clears it.
- R11: A write and a read of the same slot in one cycle return the pre-write oldest entry, store the new result and never set overrun.
- R12: Slots are independent: writes and reads of one slot leave the contents and flags of every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_dbuf_en | input | SLOTS | Per-slot double-buffer enable |
| wr_stb | input | 1 | Conversion completion strobe |
| wr_slot | input | SLOT_W | Slot that receives the result |
| wr_result | input | RES_W | Conversion result |
| rd_stb | input | 1 | Bus read request |
| rd_slot | input | SLOT_W | Slot to read |
| rd_ack | output | 1 | Read word is present, one cycle after `rd_stb` |
| rd_word | output | 32 | Result with flags |

## Verification
The bench targets these corner cases:

- A write and a read of the same full slot in the same cycle. A design that pushes before it pops would raise a false overrun or drop the wrong entry.
- Overflow of a buffered slot. A design that overwrote the newest entry would return the stale result first.
- Single-mode slots. A design that shared the buffered occupancy rule there would show status 1 or keep two entries.
- Reads of empty slots and reads right after reset. A design that did not mask the stored data would leak an old result with valid 0.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int RESULT_W = 12;
  localparam int WORD_W   = 32;
  localparam int OVR_POS  = 16;
  localparam int VLD_POS  = 17;
  localparam int SEC_POS  = 18;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [15:0] data,
    input logic        ovr,
    input logic        vld,
    input logic        sec
  );
    logic [WORD_W-1:0] w;
    w          = '0;
    w[15:0]    = data;
    w[OVR_POS] = ovr;
    w[VLD_POS] = vld;
    w[SEC_POS] = sec;
    return w;
  endfunction
endpackage

// File: rtl/rb_slot_state.sv
module rb_slot_state (
  input  logic       clk,
  input  logic       rst,
  input  logic       dbuf_en,
  input  logic       wr_hit,
  input  logic       rd_hit,
  output logic [1:0] occ_q,
  output logic       head_q,
  output logic       ovr_q,
  output logic       wr_idx
);
  logic full;
  logic pop;
  logic head_adv;

  always_comb begin
    full     = dbuf_en ? (occ_q == 2'd2) : (occ_q != 2'd0);
    pop      = rd_hit && (occ_q != 2'd0);
    // overwrite the oldest location on a full write, else append after head
    wr_idx   = (full && !pop) ? head_q : (head_q ^ occ_q[0]);
    head_adv = pop || (wr_hit && full && dbuf_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q  <= 2'd0;
      head_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (head_adv) head_q <= ~head_q;
      if (pop && !wr_hit)
        occ_q <= occ_q - 2'd1;
      else if (wr_hit && !pop && !full)
        occ_q <= occ_q + 2'd1;
      if (rd_hit)
        ovr_q <= 1'b0;
      else if (wr_hit && full)
        ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rb_store.sv
module rb_store #(
  parameter int DW = 12,
  parameter int AW = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first: a same-address write in this cycle is not seen
  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank #(
  parameter int SLOTS = 4,
  parameter int RES_W = rb_pkg::RESULT_W,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int AW     = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOTS-1:0]  slot_dbuf_en,
  input  logic              wr_stb,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [RES_W-1:0]  wr_result,
  input  logic              rd_stb,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_ack,
  output logic [31:0]       rd_word
);
  logic [SLOTS-1:0]   wr_hit;
  logic [SLOTS-1:0]   rd_hit;
  logic [SLOTS-1:0]   head_vec;
  logic [SLOTS-1:0]   ovr_vec;
  logic [SLOTS-1:0]   widx_vec;
  logic [2*SLOTS-1:0] occ_flat;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign wr_hit[s] = wr_stb && (wr_slot == SLOT_W'(s));
    assign rd_hit[s] = rd_stb && (rd_slot == SLOT_W'(s));

    rb_slot_state u_state (
      .clk     (clk),
      .rst     (rst),
      .dbuf_en (slot_dbuf_en[s]),
      .wr_hit  (wr_hit[s]),
      .rd_hit  (rd_hit[s]),
      .occ_q   (occ_flat[2*s +: 2]),
      .head_q  (head_vec[s]),
      .ovr_q   (ovr_vec[s]),
      .wr_idx  (widx_vec[s])
    );
  end

  logic [AW-1:0]    waddr;
  logic [AW-1:0]    raddr;
  logic [RES_W-1:0] data_q;
  logic [1:0]       sel_occ;

  assign waddr   = {wr_slot, widx_vec[wr_slot]};
  assign raddr   = {rd_slot, head_vec[rd_slot]};
  assign sel_occ = occ_flat[2*rd_slot +: 2];

  rb_store #(.DW(RES_W), .AW(AW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_stb),
    .waddr (waddr),
    .wdata (wr_result),
    .re    (rd_stb),
    .raddr (raddr),
    .rdata (data_q)
  );

  logic ack_q, vld_q, sec_q, ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      vld_q <= 1'b0;
      sec_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ack_q <= rd_stb;
      if (rd_stb) begin
        vld_q <= (sel_occ != 2'd0);
        sec_q <= slot_dbuf_en[rd_slot] && (sel_occ == 2'd2);
        ovf_q <= ovr_vec[rd_slot];
      end
    end
  end

  assign rd_ack  = ack_q;
  assign rd_word = rb_pkg::pack_word(vld_q ? 16'(data_q) : 16'd0, ovf_q, vld_q, sec_q);
endmodule

// File: rtl/rb_chk.sv
module rb_chk #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [SLOT_W-1:0] wr_slot,
  input logic              rd_stb,
  input logic [SLOT_W-1:0] rd_slot,
  input logic              rd_ack,
  input logic [2:0]        rd_flags,
  input logic [2*SLOTS-1:0] occ_flat,
  input logic [SLOTS-1:0]  ovr_vec
);
  function automatic logic [1:0] occ_of(input logic [SLOT_W-1:0] i);
    return occ_flat[2*i +: 2];
  endfunction

  // R2
  ack_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_ack);

  // R3
  status_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && rd_flags[2]) |-> rd_flags[1]);

  // R5
  fill_from_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !rd_stb && occ_of(wr_slot) == 2'd0)
      |=> occ_of($past(wr_slot)) == 2'd1);

  // R7
  read_drains_one_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !(wr_stb && wr_slot == rd_slot) && occ_of(rd_slot) != 2'd0)
      |=> occ_of($past(rd_slot)) == $past(occ_of(rd_slot)) - 2'd1);

  // R8
  overrun_on_full_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !rd_stb && occ_of(wr_slot) == 2'd2) |=> ovr_vec[$past(wr_slot)]);

  // R10
  read_clears_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !ovr_vec[$past(rd_slot)]);
endmodule

bind conv_result_bank rb_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_stb   (wr_stb),
  .wr_slot  (wr_slot),
  .rd_stb   (rd_stb),
  .rd_slot  (rd_slot),
  .rd_ack   (rd_ack),
  .rd_flags (rd_word[18:16]),
  .occ_flat (occ_flat),
  .ovr_vec  (ovr_vec)
);

// File: tb/tb_conv_result_bank.sv
module tb_conv_result_bank;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] slot_dbuf_en = '0;
  logic        wr_stb = 1'b0;
  logic [1:0]  wr_slot = '0;
  logic [11:0] wr_result = '0;
  logic        rd_stb = 1'b0;
  logic [1:0]  rd_slot = '0;
  logic        rd_ack;
  logic [31:0] rd_word;

  conv_result_bank #(.SLOTS(N), .RES_W(12)) dut (
    .clk(clk), .rst(rst), .slot_dbuf_en(slot_dbuf_en),
    .wr_stb(wr_stb), .wr_slot(wr_slot), .wr_result(wr_result),
    .rd_stb(rd_stb), .rd_slot(rd_slot), .rd_ack(rd_ack), .rd_word(rd_word)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  int m_cnt [N];
  int m_q0  [N];
  int m_q1  [N];
  bit m_ovr [N];
  logic [31:0] last_word = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input bit vld, input bit sec, input bit ovr, input int data);
    logic [31:0] w;
    w = '0;
    if (vld) w[11:0] = data[11:0];
    w[16] = ovr;
    w[17] = vld;
    w[18] = sec;
    return w;
  endfunction

  function automatic logic [31:0] mdl_peek(input int s);
    return mk_word(m_cnt[s] > 0, slot_dbuf_en[s] && m_cnt[s] == 2, m_ovr[s], m_q0[s]);
  endfunction

  task automatic mdl_step(input bit w, input int ws, input int wd, input bit r, input int rs);
    int cap;
    if (r) begin
      if (m_cnt[rs] > 0) begin
        m_q0[rs] = m_q1[rs];
        m_cnt[rs]--;
      end
      m_ovr[rs] = 1'b0;
    end
    if (w) begin
      cap = slot_dbuf_en[ws] ? 2 : 1;
      if (m_cnt[ws] < cap) begin
        if (m_cnt[ws] == 0) m_q0[ws] = wd; else m_q1[ws] = wd;
        m_cnt[ws]++;
      end else begin
        if (cap == 2) begin m_q0[ws] = m_q1[ws]; m_q1[ws] = wd; end
        else m_q0[ws] = wd;
        m_ovr[ws] = 1'b1;
      end
    end
  endtask

  task automatic step(input bit w, input int ws, input int wd, input bit r, input int rs, input string tag);
    logic [31:0] expw;
    @(negedge clk);
    wr_stb = w; wr_slot = 2'(ws); wr_result = 12'(wd);
    rd_stb = r; rd_slot = 2'(rs);
    expw = r ? mdl_peek(rs) : last_word;
    mdl_step(w, ws, wd, r, rs);
    @(posedge clk); #1;
    if (r) begin
      chk(rd_ack == 1'b1, "R2 ack", {31'd0, rd_ack}, 32'd1);
      chk(rd_word == expw, tag, rd_word, expw);
      last_word = expw;
    end else begin
      chk(rd_ack == 1'b0 && rd_word == last_word, "R2 hold", rd_word, last_word);
    end
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    for (int s = 0; s < N; s++) begin m_cnt[s] = 0; m_ovr[s] = 0; m_q0[s] = 0; m_q1[s] = 0; end
    last_word = '0;
    chk(rd_ack == 1'b0 && rd_word == 32'd0, "R1 reset", rd_word, 32'd0);
    for (int s = 0; s < N; s++) step(0, 0, 0, 1, s, "R1 empty after reset");
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      bit w, r;
      w = ($urandom % 2) == 0;
      r = ($urandom % 5) < 2;
      step(w, $urandom % N, $urandom % 4096, r, $urandom % N, "R7/R12 random");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    slot_dbuf_en = 4'b0101;  // R4: slots 0,2 buffered, 1,3 single
    do_reset();

    // R5
    step(1, 0, 12'hA11, 0, 0, "");
    step(0, 0, 0, 1, 0, "R5 first result");
    step(0, 0, 0, 1, 0, "R7 empty after drain");
    // R6 then R7
    step(1, 0, 12'h101, 0, 0, "");
    step(1, 0, 12'h202, 0, 0, "");
    step(0, 0, 0, 1, 0, "R6 both flags, oldest first");
    step(0, 0, 0, 1, 0, "R7 remaining entry");
    // R8 then R10
    step(1, 2, 12'h111, 0, 0, "");
    step(1, 2, 12'h222, 0, 0, "");
    step(1, 2, 12'h333, 0, 0, "");
    step(0, 0, 0, 1, 2, "R8 oldest dropped, overrun");
    step(0, 0, 0, 1, 2, "R10 overrun cleared");
    // R9 single mode
    step(1, 1, 12'h0AA, 0, 0, "");
    step(1, 1, 12'h0BB, 0, 0, "");
    step(0, 0, 0, 1, 1, "R9 replace, status 0, overrun");
    step(0, 0, 0, 1, 1, "R9 empty after read");
    // R11 simultaneous write and read on a full slot
    step(1, 0, 12'h701, 0, 0, "");
    step(1, 0, 12'h702, 0, 0, "");
    step(1, 0, 12'h703, 1, 0, "R11 read returns pre-write head");
    step(0, 0, 0, 1, 0, "R11 second entry");
    step(0, 0, 0, 1, 0, "R11 new entry kept, no overrun");
    // R12 isolation
    step(1, 3, 12'hFED, 0, 0, "");
    step(1, 2, 12'h0C0, 0, 0, "");
    step(0, 0, 0, 1, 3, "R12 slot 3 untouched by slot 2");
    step(0, 0, 0, 1, 2, "R12 slot 2");
    rand_run(4000);

    slot_dbuf_en = 4'b1010;  // R4: modes swapped
    do_reset();
    step(1, 0, 12'h055, 0, 0, "");
    step(1, 0, 12'h066, 0, 0, "");
    step(0, 0, 0, 1, 0, "R4 R9 slot 0 now single");
    rand_run(4000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule